// File: doc/BRIEF.md
# Grouped Interrupt Level Controller

This block gathers thirteen peripheral interrupt request lines into one 32-bit pending-status register. Each line owns one fixed status bit. A 32-bit enable register sits beside the status register, and software can read and write both through a simple register port. From the pending bits that are enabled, the block drives a 3-bit priority level to the processor. Each source belongs to one of three fixed groups, at levels 3, 5 and 6. The output is the highest group that holds at least one enabled pending source.

The block captures a request line on its transitions. A rising edge sets the line's status bit and a falling edge clears it. Software can therefore clear or set a bit by hand while the line holds steady.

Two side inputs also act on the status register. The first is a strobe from the disk-controller DMA control path, which forces the disk DMA bit to the value of the enable flag that comes with it. The second is a clear strobe from the clock chip's status-clear command, which drops the power bit.

Top module: `irq_level_ctrl`

## Requirements
- R1: After synchronous reset, the status register reads 0, the enable register reads 0, and `ipl` is 0.
- R2: A rising edge on `irq_src[i]` sets one status bit in the clock edge that samples it. The index-to-bit mapping is: 0→7 (floppy), 1→3 (keyboard/mouse), 2→2 (power), 3→9 (network receive), 4→10 (network transmit), 5→12 (disk controller), 6→5 (timer), 7→17 (serial), 8→28 (network transmit DMA), 9→27 (network receive DMA), 10→26 (disk DMA), 11→23 (sound), 12→21 (serial DMA).
- R3: A falling edge on `irq_src[i]` clears the mapped status bit.
- R4: A write at offset 0x7000 replaces the status register, and a write at 0x7800 replaces the enable register. Reads at those offsets return the registers. Any other offset reads 0 and its writes change neither register.
- R5: `ipl` is 6 when any enabled pending bit is in {21,23,26,27,28}. Otherwise it is 5 when bit 17 is enabled and pending. Otherwise it is 3 when any enabled pending bit is in {2,3,5,7,9,10,12}. Otherwise it is 0.
- R6: Status bits not mapped to any source never raise `ipl`, even when they are set and enabled.
- R7: A pending source whose enable bit is 0 does not count toward `ipl`.
- R8: When a software write to the status register and a source edge fall in the same cycle, the source set or clear is applied on top of the written value.
- R9: A cycle with `dma_ctl_stb` high loads bit 26 with `dma_ctl_on`. This takes precedence over both a software write and an index-10 edge in the same cycle.
- R10: `pwr_ack_clr` clears bit 2. This takes precedence over a software write and an index-2 rising edge in the same cycle.
- R11: A request line held at a steady level does not set its bit again after software has cleared it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_src | input | 13 | Peripheral request lines, captured on edges |
| dma_ctl_stb | input | 1 | Strobe that loads the disk DMA bit |
| dma_ctl_on | input | 1 | Value loaded into the disk DMA bit on the strobe |
| pwr_ack_clr | input | 1 | Strobe that clears the power bit |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | AW (16) | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| ipl | output | 3 | Processor priority level: 0, 3, 5 or 6 |

## Verification
The hardest situation to reach from the ports is a collision: a software write, a request edge, a DMA-control strobe and a power-clear strobe all landing in the same clock cycle. Only the precedence order decides the resulting status value in that case. Directed cases line up each pair of colliding updates at a single negative edge. A long random phase then toggles lines, strobes and writes independently, so that triple and quadruple collisions also occur, and compares them against a bench model of the update order. A held-line case clears a bit by software and then confirms that the steady level does not set it again.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int NSRC = 13;
    localparam int DW   = 32;

    typedef logic [4:0] bitpos_t;

    typedef enum logic [2:0] {
        LVL_NONE = 3'd0,
        LVL_LOW  = 3'd3,
        LVL_MID  = 3'd5,
        LVL_HIGH = 3'd6
    } lvl_e;

    typedef struct packed {
        logic [DW-1:0] set;
        logic [DW-1:0] clr;
    } hw_upd_t;

    localparam bitpos_t DMA_CTL_BIT = 5'd26;
    localparam bitpos_t PWR_BIT     = 5'd2;

    // status bit owned by each source index
    function automatic bitpos_t src_bit(input int idx);
        case (idx)
            0:       return 5'd7;
            1:       return 5'd3;
            2:       return 5'd2;
            3:       return 5'd9;
            4:       return 5'd10;
            5:       return 5'd12;
            6:       return 5'd5;
            7:       return 5'd17;
            8:       return 5'd28;
            9:       return 5'd27;
            10:      return 5'd26;
            11:      return 5'd23;
            default: return 5'd21;
        endcase
    endfunction

    // priority group of each source index
    function automatic lvl_e src_grp(input int idx);
        if (idx <= 6)      return LVL_LOW;
        else if (idx == 7) return LVL_MID;
        else               return LVL_HIGH;
    endfunction

    // all status bits that belong to one group
    function automatic logic [DW-1:0] grp_mask(input lvl_e g);
        logic [DW-1:0] m;
        m = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (src_grp(i) == g) m[src_bit(i)] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [DW-1:0] G_LOW  = grp_mask(LVL_LOW);
    localparam logic [DW-1:0] G_MID  = grp_mask(LVL_MID);
    localparam logic [DW-1:0] G_HIGH = grp_mask(LVL_HIGH);

endpackage

// File: rtl/irqc_edge.sv
module irqc_edge #(
    parameter int N = 13
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl_in,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lvl_in;
    end

    assign rise = lvl_in & ~prev_q;
    assign fall = ~lvl_in & prev_q;
endmodule

// File: rtl/irqc_map.sv
module irqc_map
    import irqc_pkg::*;
(
    input  logic [NSRC-1:0] rise,
    input  logic [NSRC-1:0] fall,
    output hw_upd_t         upd
);
    always_comb begin
        upd = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (rise[i]) upd.set[src_bit(i)] = 1'b1;
            if (fall[i]) upd.clr[src_bit(i)] = 1'b1;
        end
    end
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int            AW     = 16,
    parameter logic [AW-1:0] ST_OFS = 'h7000,
    parameter logic [AW-1:0] MK_OFS = 'h7800
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  hw_upd_t       upd,
    input  logic          dma_stb,
    input  logic          dma_on,
    input  logic          pwr_clr,
    output logic [DW-1:0] status,
    output logic [DW-1:0] mask
);
    logic [DW-1:0] stat_q, mask_q, stat_d, mask_d;
    logic          hit_st, hit_mk;

    assign hit_st = (addr == ST_OFS);
    assign hit_mk = (addr == MK_OFS);

    // update order: software, then source edges, then DMA control, then power clear
    always_comb begin
        stat_d = stat_q;
        if (wr && hit_st) stat_d = wdata;
        stat_d = (stat_d & ~upd.clr) | upd.set;
        if (dma_stb) stat_d[DMA_CTL_BIT] = dma_on;
        if (pwr_clr) stat_d[PWR_BIT] = 1'b0;
    end

    always_comb begin
        mask_d = mask_q;
        if (wr && hit_mk) mask_d = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            mask_q <= '0;
        end else begin
            stat_q <= stat_d;
            mask_q <= mask_d;
        end
    end

    always_comb begin
        if (hit_st)      rdata = stat_q;
        else if (hit_mk) rdata = mask_q;
        else             rdata = '0;
    end

    assign status = stat_q;
    assign mask   = mask_q;
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio
    import irqc_pkg::*;
(
    input  logic [DW-1:0] status,
    input  logic [DW-1:0] mask,
    output lvl_e          lvl
);
    localparam int NG = 3;
    localparam logic [NG-1:0][DW-1:0] GM = {G_HIGH, G_MID, G_LOW};

    logic [DW-1:0] pend;
    logic [NG-1:0] hit;

    assign pend = status & mask;

    for (genvar g = 0; g < NG; g++) begin : g_grp
        assign hit[g] = |(pend & GM[g]);
    end

    always_comb begin
        if (hit[2])      lvl = LVL_HIGH;
        else if (hit[1]) lvl = LVL_MID;
        else if (hit[0]) lvl = LVL_LOW;
        else             lvl = LVL_NONE;
    end
endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
    import irqc_pkg::*;
#(
    parameter int            AW     = 16,
    parameter logic [AW-1:0] ST_OFS = 'h7000,
    parameter logic [AW-1:0] MK_OFS = 'h7800
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] irq_src,
    input  logic            dma_ctl_stb,
    input  logic            dma_ctl_on,
    input  logic            pwr_ack_clr,
    input  logic            reg_wr,
    input  logic [AW-1:0]   reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    output logic [2:0]      ipl
);
    logic [NSRC-1:0] rise, fall;
    hw_upd_t         upd;
    logic [DW-1:0]   stat_w, mask_w;
    lvl_e            lvl;

    irqc_edge #(.N(NSRC)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .lvl_in (irq_src),
        .rise   (rise),
        .fall   (fall)
    );

    irqc_map u_map (
        .rise (rise),
        .fall (fall),
        .upd  (upd)
    );

    irqc_regs #(.AW(AW), .ST_OFS(ST_OFS), .MK_OFS(MK_OFS)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .upd     (upd),
        .dma_stb (dma_ctl_stb),
        .dma_on  (dma_ctl_on),
        .pwr_clr (pwr_ack_clr),
        .status  (stat_w),
        .mask    (mask_w)
    );

    irqc_prio u_prio (
        .status (stat_w),
        .mask   (mask_w),
        .lvl    (lvl)
    );

    assign ipl = lvl;
endmodule

// File: rtl/irq_level_ctrl_chk.sv
module irq_level_ctrl_chk
    import irqc_pkg::*;
#(
    parameter int            AW     = 16,
    parameter logic [AW-1:0] ST_OFS = 'h7000,
    parameter logic [AW-1:0] MK_OFS = 'h7800
) (
    input logic            clk,
    input logic            rst,
    input logic [NSRC-1:0] irq_src,
    input logic            dma_ctl_stb,
    input logic            dma_ctl_on,
    input logic            pwr_ack_clr,
    input logic            reg_wr,
    input logic [AW-1:0]   reg_addr,
    input logic [DW-1:0]   reg_wdata,
    input logic [2:0]      ipl,
    input logic [DW-1:0]   stat,
    input logic [DW-1:0]   mask
);
    // R2
    floppy_rise_sets_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_src[0]) |=> stat[7]);

    // R3
    floppy_fall_clears_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_src[0]) |=> !stat[7]);

    // R4
    mask_write_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == MK_OFS) |=> (mask == $past(reg_wdata)));

    // R5
    ipl_legal_chk: assert property (@(posedge clk) disable iff (rst)
        (ipl == 3'd0 || ipl == 3'd3 || ipl == 3'd5 || ipl == 3'd6));

    // R5
    ipl_high_backed_chk: assert property (@(posedge clk) disable iff (rst)
        (ipl == 3'd6) |-> (|(stat & mask & G_HIGH)));

    // R8
    edge_over_write_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == ST_OFS && $rose(irq_src[1])) |=> stat[3]);

    // R9
    dma_ctl_load_chk: assert property (@(posedge clk) disable iff (rst)
        dma_ctl_stb |=> (stat[26] == $past(dma_ctl_on)));

    // R10
    pwr_clear_chk: assert property (@(posedge clk) disable iff (rst)
        pwr_ack_clr |=> !stat[2]);
endmodule

bind irq_level_ctrl irq_level_ctrl_chk #(.AW(AW), .ST_OFS(ST_OFS), .MK_OFS(MK_OFS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .irq_src     (irq_src),
    .dma_ctl_stb (dma_ctl_stb),
    .dma_ctl_on  (dma_ctl_on),
    .pwr_ack_clr (pwr_ack_clr),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .ipl         (ipl),
    .stat        (stat_w),
    .mask        (mask_w)
);

// File: tb/irq_level_ctrl_test.sv
module irq_level_ctrl_test;
    localparam logic [15:0] ST = 16'h7000;
    localparam logic [15:0] MK = 16'h7800;

    logic        clk = 1'b0;
    logic        rst;
    logic [12:0] src;
    logic        dstb, don, pclr, wr;
    logic [15:0] addr;
    logic [31:0] wd, rd;
    logic [2:0]  ipl;
    int          errs = 0;
    int          checks = 0;

    always #5 clk = ~clk;

    irq_level_ctrl uut (
        .clk(clk), .rst(rst), .irq_src(src), .dma_ctl_stb(dstb), .dma_ctl_on(don),
        .pwr_ack_clr(pclr), .reg_wr(wr), .reg_addr(addr), .reg_wdata(wd),
        .reg_rdata(rd), .ipl(ipl)
    );

    function automatic int bpos(input int i);
        case (i)
            0: return 7;   1: return 3;   2: return 2;   3: return 9;
            4: return 10;  5: return 12;  6: return 5;   7: return 17;
            8: return 28;  9: return 27;  10: return 26; 11: return 23;
            default: return 21;
        endcase
    endfunction

    function automatic logic [2:0] glvl(input int i);
        if (i <= 6) return 3'd3;
        if (i == 7) return 3'd5;
        return 3'd6;
    endfunction

    function automatic logic [2:0] exp_ipl(input logic [31:0] s, input logic [31:0] m);
        logic [2:0] r = 3'd0;
        for (int i = 0; i < 13; i++)
            if (s[bpos(i)] && m[bpos(i)] && glvl(i) > r) r = glvl(i);
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rdreg(input logic [15:0] a, output logic [31:0] v);
        wr = 1'b0;
        addr = a;
        #1 v = rd;
    endtask

    task automatic wrreg(input logic [15:0] a, input logic [31:0] d);
        wr = 1'b1; addr = a; wd = d;
        tick();
        wr = 1'b0;
    endtask

    initial begin : watchdog
        #2_000_000;
        errs++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin : main
        logic [31:0] v, ms, mm;
        logic [12:0] mp;
        void'($urandom(32'd20240611));
        rst = 1'b1; src = '0; dstb = 0; don = 0; pclr = 0; wr = 0; addr = ST; wd = '0;
        @(negedge clk);
        tick(); tick();
        rst = 1'b0;

        // R1 reset state
        rdreg(ST, v); chk("R1 status", v, 0);
        rdreg(MK, v); chk("R1 mask", v, 0);
        chk("R1 ipl", ipl, 0);

        // R4 register access
        wrreg(MK, 32'hFFFF_FFFF);
        rdreg(MK, v); chk("R4 mask readback", v, 32'hFFFF_FFFF);
        wrreg(16'h7400, 32'h1234_5678);
        rdreg(16'h7400, v); chk("R4 unmapped read", v, 0);
        rdreg(ST, v); chk("R4 unmapped write status", v, 0);
        rdreg(MK, v); chk("R4 unmapped write mask", v, 32'hFFFF_FFFF);

        // R2 sets and R5 levels
        src[0] = 1'b1; tick();
        rdreg(ST, v); chk("R2 floppy bit7", v, 32'h80);
        chk("R5 level3", ipl, 3);
        src[7] = 1'b1; tick();
        rdreg(ST, v); chk("R2 serial bit17", v, 32'h2_0080);
        chk("R5 level5", ipl, 5);
        src[11] = 1'b1; tick();
        chk("R5 level6", ipl, 6);

        // R3 clear on fall
        src[11] = 1'b0; tick();
        rdreg(ST, v); chk("R3 sound bit23 cleared", v, 32'h2_0080);
        chk("R3 ipl back to 5", ipl, 5);

        // R7 disabled source ignored
        wrreg(MK, ~32'h2_0000);
        chk("R7 serial disabled", ipl, 3);
        wrreg(MK, 32'hFFFF_FFFF);

        // R6 unmapped bits never raise level
        src = '0; tick();
        wrreg(ST, 32'h8000_0001);
        chk("R6 unmapped bits", ipl, 0);

        // R11 steady level does not re-set
        src[1] = 1'b1; tick();
        wrreg(ST, 32'h0);
        tick(); tick();
        rdreg(ST, v); chk("R11 held line stays cleared", v, 0);

        // R8 edge applied after software write
        wr = 1'b1; addr = ST; wd = 32'h0000_1000; src[4] = 1'b1;
        tick(); wr = 1'b0;
        rdreg(ST, v); chk("R8 write plus rise", v, 32'h0000_1400);
        wr = 1'b1; addr = ST; wd = 32'hFFFF_FFFF; src[4] = 1'b0;
        tick(); wr = 1'b0;
        rdreg(ST, v); chk("R8 write plus fall", v, 32'hFFFF_FBFF);
        wrreg(ST, 32'h0);

        // R9 DMA control beats disk DMA edge
        src[10] = 1'b1; dstb = 1'b1; don = 1'b0;
        tick(); dstb = 1'b0;
        rdreg(ST, v); chk("R9 strobe off beats rise", v, 0);
        src[10] = 1'b0; dstb = 1'b1; don = 1'b1;
        tick(); dstb = 1'b0;
        rdreg(ST, v); chk("R9 strobe on beats fall", v, 32'h0400_0000);
        chk("R9 ipl from dma bit", ipl, 6);
        wrreg(ST, 32'h0);

        // R10 power clear beats rise and write
        src[2] = 1'b1; pclr = 1'b1; wr = 1'b1; addr = ST; wd = 32'h4;
        tick(); pclr = 1'b0; wr = 1'b0;
        rdreg(ST, v); chk("R10 clear beats rise", v, 0);
        src[2] = 1'b0; tick();

        // random phase against a model
        src = '0; tick();
        wrreg(MK, 32'hFFFF_FFFF);
        wrreg(ST, 32'h0);
        ms = 32'h0; mm = 32'hFFFF_FFFF; mp = '0;
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] ns;
            src ^= 13'($urandom) & 13'($urandom) & 13'($urandom);
            wr = (($urandom % 4) == 0);
            case ($urandom % 3)
                0: addr = ST;
                1: addr = MK;
                default: addr = 16'h1234;
            endcase
            wd = $urandom;
            dstb = (($urandom % 8) == 0);
            don = $urandom % 2;
            pclr = (($urandom % 8) == 0);
            #1;
            chk("R4 random read", rd, (addr == ST) ? ms : (addr == MK) ? mm : 32'h0);
            ns = ms;
            if (wr && addr == ST) ns = wd;
            for (int i = 0; i < 13; i++) begin
                if (src[i] && !mp[i]) ns[bpos(i)] = 1'b1;
                if (!src[i] && mp[i]) ns[bpos(i)] = 1'b0;
            end
            if (dstb) ns[26] = don;
            if (pclr) ns[2] = 1'b0;
            if (wr && addr == MK) mm = wd;
            ms = ns;
            mp = src;
            tick();
            chk("R5 random level", ipl, exp_ipl(ms, mm));
        end
        wr = 0; dstb = 0; pclr = 0;

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule